// File: doc/BRIEF.md
# Programmable Power-of-Two Input Debouncer

This block cleans up one asynchronous input pin before it reaches the edge-detect and interrupt logic of a general-purpose I/O cell. The raw pin first crosses into the clock domain through a short flop chain. A window counter then decides when the synchronised level is trusted. The counter advances only on a millisecond tick pulse that comes from outside the block. The window length is a power of two milliseconds, chosen by a 3-bit exponent from 1 ms (exponent 0) up to 128 ms (exponent 7).

A separate enable input selects the filtered path. When it is low, the synchronised pin is passed straight to the output, and the counter and tick are ignored. The exponent is captured only while the counter is idle, so a new setting never shortens or stretches a window that is already running. The reset line is asynchronous on assertion and synchronised on release. After reset the output is loaded directly from the synchronised pin, so the first value needs no window.

Top module: `pin_debouncer`

## Requirements
- R1: While reset is asserted, `clean_out` is 0. Within 8 clock cycles after reset is released, `clean_out` equals the level held on `pin_raw`, and no `ms_tick` pulse is needed for this.
- R2: When `db_enable` is 0, `clean_out` follows `pin_raw` with a latency of exactly three clock edges (two synchroniser flops and the output flop). Ticks have no effect in this mode.
- R3: When `db_enable` is 1, `clean_out` takes the new pin level only after the synchronised pin has differed from `clean_out` for 2^`db_exp` consecutive `ms_tick` pulses. After one pulse fewer, `clean_out` still holds its old level.
- R4: Exponent 0 gives a one-tick window and exponent 7 gives a 128-tick window.
- R5: If the synchronised pin returns to the level of `clean_out` before the window completes, the tick count restarts from zero. The next mismatch again needs the full window.
- R6: A change of `db_exp` while a window is being counted does not alter that window. The new value applies from the next restart.
- R7: Ticks that arrive while the synchronised pin equals `clean_out` leave `clean_out` unchanged.
- R8: The internal tick count never reaches or exceeds the current window length, and `clean_out` changes in enabled mode only on a cycle that follows a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ms_tick | input | 1 | One-cycle pulse per millisecond that advances the window counter |
| pin_raw | input | 1 | Asynchronous raw pin level |
| db_enable | input | 1 | 1 selects the filtered path, 0 selects pass-through |
| db_exp | input | 3 | Window exponent; window = 2^db_exp ticks |
| clean_out | output | 1 | Filtered pin level |

## Verification
The hardest situation to reach from the ports is a window that ends exactly on its last tick after it has already been restarted by a bounce, or after the exponent was changed while it was running. Both depend on the hidden count and the latched exponent. The stimulus reaches these states through directed sequences. Each sequence moves the pin, waits out the synchroniser and then issues an exact number of tick pulses. One sequence bounces the pin back part-way through a window, and another rewrites the exponent part-way through. A seeded random phase then draws exponents and hold lengths that fall on both sides of the window boundary. Each hold that does not complete a window is followed by a bounce back, which exercises the restart path many times.

// File: rtl/pin_debouncer_pkg.sv
package pin_debouncer_pkg;

  // Phase of the output filter: priming after reset, then normal running.
  typedef enum logic {
    DB_FILL = 1'b0,
    DB_RUN  = 1'b1
  } db_phase_e;

  // Window length for a given exponent, as a count of ticks.
  function automatic int unsigned win_ticks(input int unsigned exp_val);
    return 32'd1 << exp_val;
  endfunction

endpackage

// File: rtl/dbn_rst_sync.sv
module dbn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb begin
        stage_d = d_async;
      end
    end else begin : g_chain
      always_comb begin
        stage_d = {stage_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/dbn_window.sv
module dbn_window #(
  parameter int EXP_W = 3,
  localparam int CNT_W = (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             mismatch,
  input  logic             ms_tick,
  input  logic [EXP_W-1:0] exp_in,
  output logic             expire,
  output logic [CNT_W-1:0] cnt_o,
  output logic [EXP_W-1:0] exp_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXP_W-1:0] exp_q, exp_d;
  logic [CNT_W:0]   win_len;
  logic [CNT_W-1:0] last_cnt;
  logic             counting;
  logic             cnt_en;

  always_comb begin
    win_len  = (CNT_W+1)'(1) << exp_q;
    last_cnt = CNT_W'(win_len - 1'b1);
    counting = run_en & mismatch;
    cnt_en   = counting & ms_tick;
    expire   = cnt_en & (cnt_q == last_cnt);
  end

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (!counting) begin
      // idle: counter held at zero, exponent tracks the control input
      cnt_d = '0;
      exp_d = exp_in;
    end else if (cnt_en) begin
      if (expire) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign cnt_o = cnt_q;
  assign exp_o = exp_q;

endmodule

// File: rtl/dbn_filter.sv
module dbn_filter
  import pin_debouncer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int FILL_W = $clog2(SYNC_STAGES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_lvl,
  input  logic db_enable,
  input  logic expire,
  output logic clean_q,
  output logic primed,
  output logic mismatch
);

  db_phase_e   phase_q, phase_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic        out_d;

  always_comb begin
    phase_d = phase_q;
    fill_d  = fill_q;
    out_d   = clean_q;
    unique case (phase_q)
      DB_FILL: begin
        if (fill_q == FILL_W'(SYNC_STAGES)) begin
          // synchroniser is full: take its level without filtering
          out_d   = sync_lvl;
          phase_d = DB_RUN;
        end else begin
          fill_d = fill_q + 1'b1;
        end
      end
      DB_RUN: begin
        if (!db_enable) begin
          out_d = sync_lvl;
        end else if (expire) begin
          out_d = sync_lvl;
        end
      end
      default: phase_d = DB_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= DB_FILL;
      fill_q  <= '0;
      clean_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      fill_q  <= fill_d;
      clean_q <= out_d;
    end
  end

  assign primed   = (phase_q == DB_RUN);
  assign mismatch = sync_lvl ^ clean_q;

endmodule

// File: rtl/pin_debouncer.sv
module pin_debouncer #(
  parameter int EXP_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  localparam int CNT_W = (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             pin_raw,
  input  logic             db_enable,
  input  logic [EXP_W-1:0] db_exp,
  output logic             clean_out
);

  logic             rst_n_s;
  logic             sync_lvl;
  logic             primed;
  logic             mismatch;
  logic             expire;
  logic             run_en;
  logic [CNT_W-1:0] win_cnt;
  logic [EXP_W-1:0] win_exp;

  dbn_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  dbn_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .d_async (pin_raw),
    .q_sync  (sync_lvl)
  );

  assign run_en = primed & db_enable;

  dbn_window #(.EXP_W(EXP_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run_en   (run_en),
    .mismatch (mismatch),
    .ms_tick  (ms_tick),
    .exp_in   (db_exp),
    .expire   (expire),
    .cnt_o    (win_cnt),
    .exp_o    (win_exp)
  );

  dbn_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sync_lvl  (sync_lvl),
    .db_enable (db_enable),
    .expire    (expire),
    .clean_q   (clean_out),
    .primed    (primed),
    .mismatch  (mismatch)
  );

endmodule

// File: rtl/pin_debouncer_chk.sv
module pin_debouncer_chk #(
  parameter int EXP_W = 3,
  localparam int CNT_W = (1 << EXP_W) - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ms_tick,
  input logic             db_enable,
  input logic             sync_lvl,
  input logic             clean_out,
  input logic             primed,
  input logic [CNT_W-1:0] win_cnt,
  input logic [EXP_W-1:0] win_exp
);

  // R8: count stays below the window length
  assert_cnt_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, win_cnt} < ((CNT_W+1)'(1) << win_exp)));

  // R8 / R3: in filtered mode the output moves only after a tick
  assert_move_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(primed) && $past(db_enable) && !$past(ms_tick)) |-> $stable(clean_out));

  // R2: pass-through copies the synchronised level
  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(primed) && !$past(db_enable)) |-> (clean_out == $past(sync_lvl)));

  // R7: an output change always moves toward the synchronised level
  assert_change_to_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(primed) && (clean_out != $past(clean_out))) |-> (clean_out == $past(sync_lvl)));

  // R5: agreement between pin and output clears the count
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && ($past(sync_lvl) == $past(clean_out))) |-> (win_cnt == '0));

  // R6: exponent frozen while a window is counting
  assert_exp_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(win_cnt) != '0) && (win_cnt != '0)) |-> $stable(win_exp));

endmodule

bind pin_debouncer pin_debouncer_chk #(.EXP_W(EXP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .ms_tick   (ms_tick),
  .db_enable (db_enable),
  .sync_lvl  (sync_lvl),
  .clean_out (clean_out),
  .primed    (primed),
  .win_cnt   (win_cnt),
  .win_exp   (win_exp)
);

// File: tb/pin_debouncer_tb.sv
module pin_debouncer_tb;

  logic       clk;
  logic       rst_n;
  logic       ms_tick;
  logic       pin_raw;
  logic       db_enable;
  logic [2:0] db_exp;
  logic       clean_out;

  int n_checks;
  int n_fail;
  bit done;

  pin_debouncer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .pin_raw   (pin_raw),
    .db_enable (db_enable),
    .db_exp    (db_exp),
    .clean_out (clean_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int unsigned window_of(input int unsigned e);
    return 32'd1 << e;
  endfunction

  function automatic logic expect_after(input logic old_v, input logic new_v,
                                        input int unsigned held, input int unsigned win);
    return (held >= win) ? new_v : old_v;
  endfunction

  task automatic check(input string req, input logic got, input logic exp_v);
    n_checks++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s: clean_out=%0b expected %0b at %0t", req, got, exp_v, $time);
    end
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge clk);
    rst_n   = 1'b0;
    pin_raw = lvl;
    clks(3);
    check("R1 reset low", clean_out, 1'b0);
    rst_n = 1'b1;
    clks(8);
    check("R1 level after reset", clean_out, lvl);
  endtask

  // Move the pin, wait out the synchroniser, give n ticks, check.
  task automatic window_run(input string req, input int unsigned e, input int unsigned n,
                            output logic expected);
    logic old_v;
    old_v = clean_out;
    pin_raw = ~old_v;
    clks(3);
    ticks(n);
    clks(2);
    expected = expect_after(old_v, ~old_v, n, window_of(e));
    check(req, clean_out, expected);
  endtask

  initial begin
    logic ev;
    logic held_v;
    rst_n     = 1'b0;
    ms_tick   = 1'b0;
    pin_raw   = 1'b0;
    db_enable = 1'b1;
    db_exp    = 3'd2;
    n_checks  = 0;
    n_fail    = 0;
    done      = 1'b0;
    void'($urandom(32'd20240611));

    // R1: reset loads the pin level directly, both polarities
    do_reset(1'b1);
    do_reset(1'b0);

    // R2: pass-through with three-edge latency, ticks ignored
    db_enable = 1'b0;
    clks(2);
    for (int k = 0; k < 2; k++) begin
      held_v = clean_out;
      pin_raw = ~held_v;
      clks(2);
      check("R2 latency not yet", clean_out, held_v);
      clks(1);
      check("R2 follows pin", clean_out, ~held_v);
    end
    ticks(4);
    check("R2 ticks ignored", clean_out, pin_raw);

    // R3 / R4: exact window boundary for several exponents
    db_enable = 1'b1;
    clks(2);
    for (int k = 0; k < 4; k++) begin
      int unsigned e;
      e = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 3 : 7;
      db_exp = 3'(e);
      clks(1);
      held_v = clean_out;
      pin_raw = ~held_v;
      clks(3);
      ticks(window_of(e) - 1);
      clks(2);
      check((k == 3) ? "R4 exp7 one short" : "R3 one tick short", clean_out, held_v);
      ticks(1);
      clks(2);
      check((k == 0 || k == 3) ? "R4 window end" : "R3 window end", clean_out, ~held_v);
    end

    // R5: bounce back restarts the count
    db_exp = 3'd3;
    clks(1);
    held_v = clean_out;
    pin_raw = ~held_v;
    clks(3);
    ticks(5);
    pin_raw = held_v;
    clks(3);
    check("R5 bounce holds", clean_out, held_v);
    pin_raw = ~held_v;
    clks(3);
    ticks(7);
    clks(2);
    check("R5 restarted window", clean_out, held_v);
    ticks(1);
    clks(2);
    check("R5 full window after restart", clean_out, ~held_v);

    // R6: exponent change mid-window is deferred
    db_exp = 3'd2;
    clks(1);
    held_v = clean_out;
    pin_raw = ~held_v;
    clks(3);
    ticks(1);
    db_exp = 3'd0;
    ticks(2);
    clks(2);
    check("R6 old window kept", clean_out, held_v);
    ticks(1);
    clks(2);
    check("R6 old window ends", clean_out, ~held_v);
    window_run("R6 new exponent applies", 0, 1, ev);

    // R7: ticks with pin equal to output change nothing
    ticks(20);
    check("R7 idle ticks", clean_out, pin_raw);

    // Random phase: exponents and hold lengths around the boundary
    for (int t = 0; t < 40; t++) begin
      int unsigned e;
      int unsigned n;
      e = $urandom_range(0, 4);
      n = $urandom_range(1, 2 * window_of(e));
      db_exp = 3'(e);
      clks(1);
      held_v = clean_out;
      window_run((n >= window_of(e)) ? "R3 random flip" : "R5 random short", e, n, ev);
      if (ev == held_v) begin
        pin_raw = held_v;
        clks(3);
        check("R5 random bounce back", clean_out, held_v);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule